// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit carries out a multi-register load or store, one word at a time. A single start cycle supplies four things: a base address, a bit-per-register selection list, one of four addressing directions and a load/store flag with a base-update flag. The unit then walks the selected registers from the lowest index to the highest. For each one it presents a word address and the register index on a request/ready handshake to memory.

Only one access is outstanding at any time. The address moves on by one word only when the memory side accepts the current request. The register file and the memory sit outside the block. On a load, the owner of the register file writes the returned word into the register named on the handshake. On a store, it supplies the data of that register.

When the last access is accepted, the unit raises a one-cycle completion strobe. With that strobe it shows the base value that the caller should write back. The lowest register always lands on the lowest address of the touched window, whatever the direction.

Top module: `blk_xfer_seq`

## Requirements
- R1: The first request address depends on the mode code and on n, the number of set bits in the list. Code 0 (up, step after) gives base. Code 1 (up, step before) gives base+4. Code 2 (down, step after) gives base-4n+4. Code 3 (down, step before) gives base-4n. All arithmetic wraps modulo 2^ADDR_W.
- R2: Requests present the selected register indices in strictly ascending order. Each request after the first has an address exactly 4 above the previous one. Exactly n requests are accepted.
- R3: At most one request is outstanding. While `mem_req` is high and `mem_ready` is low, the address, register index and direction are held unchanged.
- R4: With the base-update flag set, `wb_value` at completion is base+4n for codes 0 and 1, and base-4n for codes 2 and 3.
- R5: With the base-update flag clear, `wb_value` at completion equals the base given at start.
- R6: `busy` is high from the cycle after an accepted start until `done`. `done` is high for exactly one cycle, in the cycle after the last accepted request. After `done`, `busy` is low.
- R7: An empty list produces no request. `done` is high in the cycle after start.
- R8: `mem_we` is high on every request of a store (`is_load`=0) and low on every request of a load (`is_load`=1).
- R9: A `start` pulse while `busy` is high is ignored. The running sequence keeps its list, addresses and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| base_addr | input | ADDR_W | Base address sampled at start |
| reg_list | input | LIST_W | One bit per register, bit i selects register i |
| mode | input | 2 | 0 up/after, 1 up/before, 2 down/after, 3 down/before |
| is_load | input | 1 | 1 = load into registers, 0 = store from registers |
| wb_en | input | 1 | 1 = report updated base, 0 = report base unchanged |
| busy | output | 1 | A transfer is in progress |
| mem_req | output | 1 | Word access request |
| mem_ready | input | 1 | Memory accepts the current request this cycle |
| mem_we | output | 1 | Direction of the current request, 1 = write |
| mem_addr | output | ADDR_W | Word address of the current request |
| mem_reg | output | IDX_W | Register index of the current request |
| done | output | 1 | One-cycle completion strobe |
| wb_value | output | ADDR_W | Base value to write back, valid with done |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 16-entry list. With those values a full list of sixteen registers reaches the widest span of 64 bytes. Small bases in the down modes also reach wraparound through address zero. Random lists, bases, modes and stall patterns on `mem_ready` cover the hold behaviour. Directed runs cover the four modes on a three-register list, the empty list and a start pulse during a busy transfer.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
   // bit 1: direction down, bit 0: step before access
   typedef enum logic [1:0] {
      XM_UP_POST = 2'b00,
      XM_UP_PRE  = 2'b01,
      XM_DN_POST = 2'b10,
      XM_DN_PRE  = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } seq_state_e;
endpackage

// File: rtl/xfer_popcount.sv
module xfer_popcount #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits_i,
   output logic [CW-1:0] count_o
);
   initial begin
      if (W < 1) $error("xfer_popcount: W must be at least 1");
      if ((1 << CW) <= W) $error("xfer_popcount: CW too narrow");
   end

   always_comb begin
      count_o = '0;
      for (int i = 0; i < W; i++) begin
         count_o = count_o + CW'(bits_i[i]);
      end
   end
endmodule

// File: rtl/xfer_lowest_pick.sv
module xfer_lowest_pick #(
   parameter int W  = 16,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  bits_i,
   output logic [W-1:0]  onehot_o,
   output logic [IW-1:0] index_o
);
   logic [W-1:0] seen_below;

   genvar g;
   generate
      for (g = 0; g < W; g++) begin : g_pick
         if (g == 0) begin : g_first
            assign seen_below[g] = 1'b0;
         end else begin : g_rest
            assign seen_below[g] = seen_below[g-1] | bits_i[g-1];
         end
         assign onehot_o[g] = bits_i[g] & ~seen_below[g];
      end
   endgenerate

   always_comb begin
      index_o = '0;
      for (int i = 0; i < W; i++) begin
         if (onehot_o[i]) index_o = index_o | IW'(i);
      end
   end
endmodule

// File: rtl/xfer_addr_plan.sv
module xfer_addr_plan
   import blk_xfer_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [AW-1:0] base_i,
   input  logic [CW-1:0] count_i,
   input  xfer_mode_e    mode_i,
   input  logic          wb_en_i,
   output logic [AW-1:0] first_o,
   output logic [AW-1:0] final_o
);
   localparam int          SH   = $clog2(WORD_BYTES);
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   initial begin
      if ((1 << SH) != WORD_BYTES) $error("xfer_addr_plan: WORD_BYTES must be a power of two");
   end

   logic [AW-1:0] span;
   assign span = AW'(count_i) << SH;

   always_comb begin
      unique case (mode_i)
         XM_UP_POST: first_o = base_i;
         XM_UP_PRE:  first_o = base_i + STEP;
         XM_DN_POST: first_o = base_i - span + STEP;
         default:    first_o = base_i - span;
      endcase
      if (!wb_en_i)      final_o = base_i;
      else if (mode_i[1]) final_o = base_i - span;
      else               final_o = base_i + span;
   end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
   import blk_xfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIST_W     = 16,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = (LIST_W > 1) ? $clog2(LIST_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [LIST_W-1:0] reg_list,
   input  logic [1:0]        mode,
   input  logic              is_load,
   input  logic              wb_en,
   output logic              busy,
   output logic              mem_req,
   input  logic              mem_ready,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [IDX_W-1:0]  mem_reg,
   output logic              done,
   output logic [ADDR_W-1:0] wb_value
);
   localparam int            CNT_W = $clog2(LIST_W + 1);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   initial begin
      if (LIST_W < 1 || LIST_W > 64) $error("blk_xfer_seq: LIST_W out of range");
      if (ADDR_W < 8) $error("blk_xfer_seq: ADDR_W too small");
      if ((1 << IDX_W) < LIST_W) $error("blk_xfer_seq: IDX_W too narrow");
   end

   seq_state_e        state_q;
   logic [LIST_W-1:0] remain_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] wb_q;
   logic              load_q;

   logic [CNT_W-1:0]  sel_count;
   logic [ADDR_W-1:0] plan_first;
   logic [ADDR_W-1:0] plan_final;
   logic [LIST_W-1:0] pick_onehot;
   logic [IDX_W-1:0]  pick_index;
   logic              accept_start;
   logic              hand_ok;
   logic              last_hand;

   xfer_popcount #(.W(LIST_W), .CW(CNT_W)) u_count (
      .bits_i  (reg_list),
      .count_o (sel_count)
   );

   xfer_addr_plan #(.AW(ADDR_W), .CW(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
      .base_i  (base_addr),
      .count_i (sel_count),
      .mode_i  (xfer_mode_e'(mode)),
      .wb_en_i (wb_en),
      .first_o (plan_first),
      .final_o (plan_final)
   );

   xfer_lowest_pick #(.W(LIST_W), .IW(IDX_W)) u_pick (
      .bits_i   (remain_q),
      .onehot_o (pick_onehot),
      .index_o  (pick_index)
   );

   assign accept_start = start && (state_q == ST_IDLE);
   assign hand_ok      = mem_req && mem_ready;
   assign last_hand    = hand_ok && ((remain_q & ~pick_onehot) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         remain_q <= '0;
         addr_q   <= '0;
         wb_q     <= '0;
         load_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept_start) begin
                  remain_q <= reg_list;
                  addr_q   <= plan_first;
                  wb_q     <= plan_final;
                  load_q   <= is_load;
                  state_q  <= (reg_list == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (hand_ok) begin
                  remain_q <= remain_q & ~pick_onehot;
                  addr_q   <= addr_q + STEP;
                  if (last_hand) state_q <= ST_FIN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign mem_req  = (state_q == ST_RUN);
   assign mem_we   = mem_req & ~load_q;
   assign mem_addr = addr_q;
   assign mem_reg  = pick_index;
   assign done     = (state_q == ST_FIN);
   assign wb_value = wb_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
   parameter int ADDR_W     = 32,
   parameter int LIST_W     = 16,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [LIST_W-1:0] reg_list,
   input logic              is_load,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [IDX_W-1:0]  mem_reg,
   input logic              done
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_reg) && $stable(mem_we)));

   a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + STEP)));

   a_r2_ascending_index: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> (!mem_req || (mem_reg > $past(mem_reg))));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !done));

   a_r7_empty_list: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (reg_list == '0)) |=> (done && !mem_req));

   a_r8_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (!mem_req || (mem_we == !$past(is_load))));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
   .ADDR_W(ADDR_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
   localparam int AW = 32;
   localparam int LW = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [LW-1:0] reg_list = '0;
   logic [1:0]    mode = '0;
   logic          is_load = 1'b0;
   logic          wb_en = 1'b0;
   logic          mem_ready = 1'b0;
   logic          busy, mem_req, mem_we, done;
   logic [AW-1:0] mem_addr, wb_value;
   logic [IW-1:0] mem_reg;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] regs [LW];

   always #5 clk = ~clk;

   blk_xfer_seq u_blk_xfer_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .reg_list(reg_list), .mode(mode), .is_load(is_load), .wb_en(wb_en),
      .busy(busy), .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_reg(mem_reg), .done(done), .wb_value(wb_value)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int popc(input logic [LW-1:0] l);
      int c = 0;
      for (int i = 0; i < LW; i++) c += int'(l[i]);
      return c;
   endfunction

   function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
      return (a * 32'd3) ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [AW-1:0] exp_first(input logic [AW-1:0] b, input int n, input logic [1:0] m);
      case (m)
         2'd0: return b;
         2'd1: return b + 32'd4;
         2'd2: return b - AW'(4 * n) + 32'd4;
         default: return b - AW'(4 * n);
      endcase
   endfunction

   function automatic logic [AW-1:0] exp_final(input logic [AW-1:0] b, input int n,
                                              input logic [1:0] m, input bit w);
      if (!w) return b;
      return m[1] ? b - AW'(4 * n) : b + AW'(4 * n);
   endfunction

   task automatic run_op(input logic [AW-1:0] b, input logic [LW-1:0] l, input logic [1:0] m,
                         input bit ld, input bit w, input bit poke);
      int n = popc(l);
      int k = 0;
      int pos = 0;
      bit fin = 0;
      bit stalled = 0;
      logic [LW-1:0] rem = l;
      logic [AW-1:0] first = exp_first(b, n, m);
      for (int i = 0; i < LW; i++) regs[i] = 32'hDEAD_0000 | i;
      @(negedge clk);
      start = 1'b1; base_addr = b; reg_list = l; mode = m; is_load = ld; wb_en = w;
      @(negedge clk);
      check(busy == 1'b1, "R6", "busy after start", busy, 1);
      for (int it = 0; it < 400 && !fin; it++) begin
         start = (poke && it == 0);        // R9: start while busy must be ignored
         if (poke && it == 0) begin
            base_addr = 32'h0000_4000; reg_list = ~l; mode = ~m; is_load = ~ld; wb_en = ~w;
         end
         mem_ready = 1'b0;
         if (done) begin
            check(k == n, "R2", "accepted count", k, n);
            check(wb_value == exp_final(b, n, m, w), w ? "R4" : "R5", "wb_value",
                  wb_value, exp_final(b, n, m, w));
            if (n == 0) check(it == 0, "R7", "empty list done delay", it, 0);
            if (poke) check(k == n, "R9", "count unchanged by busy start", k, n);
            fin = 1;
         end else if (mem_req) begin
            int lo = 0;
            for (int i = LW - 1; i >= 0; i--) if (rem[i]) lo = i;
            check(k < n, "R2", "extra request", k, n);
            check(mem_addr == first + AW'(4 * k), (k == 0) ? "R1" : (stalled ? "R3" : "R2"),
                  "address", mem_addr, first + AW'(4 * k));
            check(mem_reg == IW'(lo), stalled ? "R3" : "R2", "register index", mem_reg, lo);
            check(mem_we == !ld, "R8", "direction", mem_we, !ld);
            if (($urandom % 4) != 0) begin
               mem_ready = 1'b1;
               if (ld) regs[mem_reg] = mem_word(mem_addr);
               rem[lo] = 1'b0;
               k++;
               stalled = 0;
            end else stalled = 1;
         end else begin
            check(0, "R6", "neither request nor done while busy", busy, 1);
         end
         @(negedge clk);
      end
      start = 1'b0;
      mem_ready = 1'b0;
      if (!fin) check(0, "R6", "done never seen", 0, 1);
      check(!done && !busy, "R6", "idle after done", {done, busy}, 0);
      if (ld) begin
         for (int i = 0; i < LW; i++) begin
            if (l[i]) begin
               check(regs[i] == mem_word(first + AW'(4 * pos)), "R2", "loaded word",
                     regs[i], mem_word(first + AW'(4 * pos)));
               pos++;
            end
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      check(!busy && !mem_req && !done, "R6", "reset state", {busy, mem_req, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R4: three-register list (1..3) in each mode
      run_op(32'h10, 16'h000E, 2'd0, 1, 1, 0);
      run_op(32'h10, 16'h000E, 2'd1, 1, 1, 0);
      run_op(32'h10, 16'h000E, 2'd2, 1, 1, 0);
      run_op(32'h10, 16'h000E, 2'd3, 0, 1, 0);
      // R5: no base update
      run_op(32'h100, 16'h8001, 2'd3, 0, 0, 0);
      // R7: empty list
      run_op(32'h200, 16'h0000, 2'd1, 1, 1, 0);
      // full list and wrap through zero
      run_op(32'h0000_0004, 16'hFFFF, 2'd3, 0, 1, 0);
      run_op(32'hFFFF_FFF0, 16'hFFFF, 2'd0, 1, 1, 0);
      // R9: start pulse during a running transfer
      run_op(32'h300, 16'h0A50, 2'd2, 1, 1, 1);
      for (int r = 0; r < 40; r++) begin
         logic [LW-1:0] l = LW'($urandom);
         if (r % 7 == 0) l = l & LW'($urandom);
         run_op({$urandom} & 32'hFFFF_FFFC, l, 2'($urandom), 1'($urandom), 1'($urandom), r % 9 == 4);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule